// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block sits in front of an oversampling audio converter and works out, from the clocks alone, how fast the converter must run. It counts master-clock rising edges within each frame-clock period and matches the count against a fixed set of legal ratios. In automatic selection the ratio picks the sampling-speed mode (normal, double or quad) and a ratio code. In manual selection the speed is always normal and only the normal-speed ratios are accepted. A new setting is taken only after two consecutive periods measure the same legal ratio.

The block also watches both clocks. A frame clock that stops shows up as a period count running past a limit. A master clock that stops is caught by a watchdog counting cycles of the free-running reference clock. Either condition withdraws the clocks-valid flag and raises the reset request until the clocks return and the ratio qualifies again. The active-low power-down input clears all state.

Every input is sampled in the reference-clock domain through synchronisers. The reference clock must run at least four times faster than the master clock. No data stream passes through the block: all pins are plain control and status levels.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While `pdn_n` is low, `speed_mode` is 0 (normal), `ratio_code` is 4, `clocks_valid` is 0, `rst_req` is 1 and `ratio_err` is 0.
- R2: With `auto_sel` high, ratios of 512, 768 and 1152 give `speed_mode` 0 (normal) and `ratio_code` 4, 5 and 6 respectively.
- R3: With `auto_sel` high, ratios of 256 and 384 give `speed_mode` 1 (double) with codes 2 and 3, and ratios of 128 and 192 give `speed_mode` 2 (quad) with codes 0 and 1.
- R4: With `auto_sel` low, `speed_mode` stays 0. Ratios 256, 384, 512, 768 and 1152 are legal with codes 2 to 6, and ratios 128 and 192 are illegal.
- R5: `speed_mode`, `ratio_code` and a rising `clocks_valid` change only when two consecutive completed periods measure the same legal ratio. A single differing period leaves them unchanged.
- R6: A completed period with an illegal ratio sets `ratio_err` and keeps the previous `speed_mode` and `ratio_code`. The next legal period clears `ratio_err`.
- R7: Once more than STOP_LIMIT (2048) master-clock rising edges occur with no frame-clock rising edge, `clocks_valid` drops. At exactly 2048 edges it still holds.
- R8: If no master-clock rising edge is seen for MCLK_TIMEOUT (64) reference cycles, `clocks_valid` drops. It stays high for 40 quiet cycles.
- R9: After power-down, a frame stop or a master-clock stop, `clocks_valid` returns only on the third frame-clock rising edge after both clocks run. The first edge starts timing, and the next two close matching legal periods.
- R10: `rst_req` is always the inverse of `clocks_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock, at least 4x the master clock |
| pdn_n | input | 1 | Power-down, active low, asynchronous clear |
| mclk_in | input | 1 | Master clock, sampled as data |
| frame_in | input | 1 | Frame (left/right) clock, sampled as data |
| auto_sel | input | 1 | 1: automatic speed selection, 0: manual (normal only) |
| speed_mode | output | 2 | 0 normal, 1 double, 2 quad |
| ratio_code | output | 3 | Code of the qualified ratio (0:128 1:192 2:256 3:384 4:512 5:768 6:1152) |
| clocks_valid | output | 1 | Both clocks present and ratio qualified |
| rst_req | output | 1 | Reset / power-save request to the converter |
| ratio_err | output | 1 | Last completed period had an illegal ratio |

## Verification
Each input edge crosses two synchroniser flops and an edge detector, so a frame-clock rising edge is seen as a measurement about three reference cycles later. The mode outputs settle one cycle after that. The stop flags follow their triggering edge or timeout by the same path. The bench drives the inputs on falling reference edges and places frame edges on master-clock falling edges, so every period holds an exact number of rising edges. It samples only after at least four quiet reference cycles following the last relevant edge, or a full frame later. Every legal and illegal ratio is swept in both selection modes. The stop limits are probed one edge or well inside the timeout on either side.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2
  } speed_e;

  localparam int NUM_RATIOS = 7;
  localparam int CODE_W     = $clog2(NUM_RATIOS);
  localparam logic [CODE_W-1:0] CODE_PD = CODE_W'(4);

  // master clocks per frame for each ratio code
  function automatic int unsigned ratio_of(input int unsigned idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      5:       return 768;
      default: return 1152;
    endcase
  endfunction

  function automatic speed_e speed_of(input int unsigned idx);
    if (idx < 2)      return SPD_QUAD;
    else if (idx < 4) return SPD_DOUBLE;
    else              return SPD_NORMAL;
  endfunction

  // manual selection only runs at normal speed: the two quad ratios are out
  function automatic logic manual_ok(input int unsigned idx);
    return idx >= 2;
  endfunction

endpackage

// File: rtl/mrd_edge_sync.sv
module mrd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
  parameter int STOP_LIMIT = 2048,
  localparam int CNT_W = $clog2(STOP_LIMIT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             mclk_rise,
  input  logic             frame_rise,
  output logic             meas_vld,
  output logic [CNT_W-1:0] meas_val,
  output logic             frame_lost
);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(STOP_LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             armed_q;

  // saturates one above the limit
  always_comb begin
    cnt_inc = cnt_q;
    if (mclk_rise && cnt_q <= LIMIT_V) cnt_inc = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      frame_lost <= 1'b0;
      meas_vld   <= 1'b0;
      meas_val   <= '0;
    end else begin
      meas_vld <= 1'b0;
      if (flush) begin
        cnt_q      <= '0;
        armed_q    <= 1'b0;
        frame_lost <= 1'b0;
      end else if (frame_rise) begin
        cnt_q      <= '0;
        armed_q    <= 1'b1;
        frame_lost <= 1'b0;
        meas_vld   <= armed_q;
        meas_val   <= cnt_inc;
      end else begin
        cnt_q <= cnt_inc;
        if (cnt_inc > LIMIT_V) begin
          frame_lost <= 1'b1;
          armed_q    <= 1'b0;
        end
      end
    end
  end

  // R7: the edge that takes the count past the limit flags a stopped frame clock
  p_stop_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !frame_rise && mclk_rise && cnt_q == LIMIT_V) |=> frame_lost);

  // R9: a measurement needs a frame edge that started timing beforehand
  p_meas_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    meas_vld |-> $past(armed_q));

  // R7: a new frame edge always ends the stop condition
  p_frame_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_rise && !flush) |=> !frame_lost);
endmodule

// File: rtl/mrd_mclk_watchdog.sv
module mrd_mclk_watchdog #(
  parameter int TIMEOUT = 64,
  localparam int W = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_rise,
  output logic mclk_lost
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      mclk_lost <= 1'b0;
    end else if (mclk_rise) begin
      cnt_q     <= '0;
      mclk_lost <= 1'b0;
    end else if (cnt_q != W'(TIMEOUT)) begin
      cnt_q     <= cnt_q + W'(1);
      mclk_lost <= (cnt_q == W'(TIMEOUT - 1));
    end
  end

  // R8: reaching the timeout without an edge raises the loss flag
  p_wd_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == W'(TIMEOUT - 1) && !mclk_rise) |=> mclk_lost);

  // R8: any master-clock edge withdraws the loss flag
  p_wd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_rise |=> !mclk_lost);
endmodule

// File: rtl/mrd_ratio_qualify.sv
module mrd_ratio_qualify
  import mrd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              auto_mode,
  input  logic              meas_vld,
  input  logic [CNT_W-1:0]  meas_val,
  output speed_e            speed_q,
  output logic [CODE_W-1:0] code_q,
  output logic              locked_q,
  output logic              err_q
);
  logic [NUM_RATIOS-1:0] hit;
  logic                  legal;
  logic [CODE_W-1:0]     code_hit, prev_code_q;
  logic                  prev_ok_q;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_match
    assign hit[g] = (meas_val == CNT_W'(ratio_of(g))) && (auto_mode || manual_ok(g));
  end

  assign legal = |hit;

  always_comb begin
    code_hit = '0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (hit[i]) code_hit = CODE_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q     <= SPD_NORMAL;
      code_q      <= CODE_PD;
      locked_q    <= 1'b0;
      err_q       <= 1'b0;
      prev_ok_q   <= 1'b0;
      prev_code_q <= '0;
    end else if (clear) begin
      locked_q  <= 1'b0;
      prev_ok_q <= 1'b0;
    end else if (meas_vld) begin
      err_q       <= !legal;
      prev_ok_q   <= legal;
      prev_code_q <= code_hit;
      if (legal && prev_ok_q && prev_code_q == code_hit) begin
        speed_q  <= auto_mode ? speed_of(32'(code_hit)) : SPD_NORMAL;
        code_q   <= code_hit;
        locked_q <= 1'b1;
      end
    end
  end

  // R5: outputs hold between measurements
  p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_vld |=> ($stable(speed_q) && $stable(code_q)));

  // R6: an illegal period never moves the mode and flags the error
  p_illegal_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && !legal && !clear) |=> ($stable(code_q) && $stable(speed_q) && err_q));

  // R4: manual selection only ever settles on normal speed
  p_manual_normal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_vld && !auto_mode && !clear) |=> speed_q == SPD_NORMAL);

  // R9: lock is only gained on a measurement
  p_lock_on_meas_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(meas_vld));
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mrd_pkg::*;
#(
  parameter int STOP_LIMIT   = 2048,
  parameter int MCLK_TIMEOUT = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk_ref,
  input  logic       pdn_n,
  input  logic       mclk_in,
  input  logic       frame_in,
  input  logic       auto_sel,
  output logic [1:0] speed_mode,
  output logic [2:0] ratio_code,
  output logic       clocks_valid,
  output logic       rst_req,
  output logic       ratio_err
);
  localparam int CNT_W = $clog2(STOP_LIMIT + 2);

  logic             mclk_rise, frame_rise;
  logic             meas_vld, frame_lost, mclk_lost, locked;
  logic [CNT_W-1:0] meas_val;
  speed_e           speed_q;
  logic [CODE_W-1:0] code_q;

  mrd_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_mclk (
    .clk(clk_ref), .rst_n(pdn_n), .din(mclk_in), .rise(mclk_rise));

  mrd_edge_sync #(.STAGES(SYNC_STAGES)) i_sync_frame (
    .clk(clk_ref), .rst_n(pdn_n), .din(frame_in), .rise(frame_rise));

  mrd_mclk_watchdog #(.TIMEOUT(MCLK_TIMEOUT)) i_watchdog (
    .clk(clk_ref), .rst_n(pdn_n), .mclk_rise(mclk_rise), .mclk_lost(mclk_lost));

  mrd_period_counter #(.STOP_LIMIT(STOP_LIMIT)) i_counter (
    .clk(clk_ref), .rst_n(pdn_n), .flush(mclk_lost),
    .mclk_rise(mclk_rise), .frame_rise(frame_rise),
    .meas_vld(meas_vld), .meas_val(meas_val), .frame_lost(frame_lost));

  mrd_ratio_qualify #(.CNT_W(CNT_W)) i_qualify (
    .clk(clk_ref), .rst_n(pdn_n), .clear(frame_lost | mclk_lost),
    .auto_mode(auto_sel), .meas_vld(meas_vld), .meas_val(meas_val),
    .speed_q(speed_q), .code_q(code_q), .locked_q(locked), .err_q(ratio_err));

  assign speed_mode   = speed_q;
  assign ratio_code   = 3'(code_q);
  assign clocks_valid = locked & ~frame_lost & ~mclk_lost;
  assign rst_req      = ~clocks_valid;

  // R7: a stopped frame clock withdraws validity at once
  p_frame_stop_r7: assert property (@(posedge clk_ref) disable iff (!pdn_n)
    frame_lost |-> rst_req);

  // R8: a stopped master clock withdraws validity at once
  p_mclk_stop_r8: assert property (@(posedge clk_ref) disable iff (!pdn_n)
    mclk_lost |-> !clocks_valid);
endmodule

// File: tb/test_mclk_ratio_detect.sv
module test_mclk_ratio_detect;
  logic clk = 1'b0;
  logic pdn_n = 1'b0, mclk = 1'b0, frame = 1'b0, auto_sel = 1'b1;
  logic [1:0] speed_mode;
  logic [2:0] ratio_code;
  logic clocks_valid, rst_req, ratio_err;

  int checks = 0, errors = 0, cycles = 0;
  int exp_speed, exp_code, exp_valid, exp_err;
  int ratios [7] = '{128, 192, 256, 384, 512, 768, 1152};

  always #2 clk = ~clk;

  mclk_ratio_detect i_mclk_ratio_detect (
    .clk_ref(clk), .pdn_n(pdn_n), .mclk_in(mclk), .frame_in(frame),
    .auto_sel(auto_sel), .speed_mode(speed_mode), .ratio_code(ratio_code),
    .clocks_valid(clocks_valid), .rst_req(rst_req), .ratio_err(ratio_err));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " speed"}, int'(speed_mode), exp_speed);
    chk({tag, " code"}, int'(ratio_code), exp_code);
    chk({tag, " valid"}, int'(clocks_valid), exp_valid);
    chk({tag, " err"}, int'(ratio_err), exp_err);
    chk("R10 rst_req", int'(rst_req), 1 - int'(clocks_valid));
  endtask

  // one master-clock period: 2 low, 2 high reference cycles
  task automatic mcyc(input logic fr);
    @(negedge clk); mclk = 1'b0; frame = fr;
    @(negedge clk);
    @(negedge clk); mclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_frame(input int r);
    for (int i = 0; i < r; i++) mcyc(i < r / 2);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic int spd_for(input int r, input logic au);
    if (!au || r >= 512) return 0;
    return (r >= 256) ? 1 : 2;
  endfunction

  task automatic sweep(input logic au);
    for (int k = 0; k < 7; k++) begin
      repeat (3) run_frame(ratios[k]);
      settle();
      if (au || k >= 2) begin
        exp_speed = spd_for(ratios[k], au);
        exp_code  = k;
        exp_valid = 1;
        exp_err   = 0;
      end else begin
        exp_err = 1;
      end
      chk_all(au ? (k < 2 ? "R3 auto quad" : (k < 4 ? "R3 auto double" : "R2 auto normal"))
                 : (k < 2 ? "R4 manual illegal" : "R4 manual legal"));
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    exp_speed = 0; exp_code = 4; exp_valid = 0; exp_err = 0;
    chk_all("R1 power-down");
    pdn_n = 1'b1;

    // R2/R3: automatic sweep over every legal ratio
    sweep(1'b1);

    // R7: frame clock stops; exactly 2048 edges still valid, 2049 not
    run_frame(512);
    for (int i = 0; i < 1536; i++) mcyc(1'b0);
    settle();
    chk("R7 valid at 2048 edges", int'(clocks_valid), 1);
    mcyc(1'b0);
    settle();
    chk("R7 lost at 2049 edges", int'(clocks_valid), 0);
    chk("R10 rst_req on frame stop", int'(rst_req), 1);
    chk("R7 mode held", int'(ratio_code), 6);

    // R9: recovery needs the third frame edge
    repeat (2) run_frame(512);
    settle();
    chk("R9 not yet valid after two edges", int'(clocks_valid), 0);
    run_frame(512);
    settle();
    exp_speed = 0; exp_code = 4; exp_valid = 1; exp_err = 0;
    chk_all("R9 recovered");

    // R8: master clock stops
    repeat (40) @(negedge clk);
    chk("R8 valid within timeout", int'(clocks_valid), 1);
    repeat (60) @(negedge clk);
    chk("R8 lost after timeout", int'(clocks_valid), 0);
    chk("R10 rst_req on mclk stop", int'(rst_req), 1);
    repeat (4) mcyc(1'b0);
    repeat (2) run_frame(256);
    settle();
    chk("R9 mclk restart needs third edge", int'(clocks_valid), 0);
    run_frame(256);
    settle();
    exp_speed = 1; exp_code = 2; exp_valid = 1; exp_err = 0;
    chk_all("R9 mclk recovered");

    // R6: illegal ratio keeps mode, flags error
    repeat (2) run_frame(1000);
    settle();
    exp_err = 1;
    chk_all("R6 illegal 1000");
    // R5: single period of a new ratio does not switch
    run_frame(512);
    run_frame(512);
    settle();
    exp_err = 0;
    chk_all("R5/R6 first legal after illegal");
    run_frame(512);
    settle();
    exp_speed = 0; exp_code = 4;
    chk_all("R5 switched after two matches");
    // R5: one 768 period then back to 512: no change
    run_frame(768);
    run_frame(512);
    run_frame(512);
    settle();
    chk_all("R5 lone 768 period ignored");

    // R1: power-down mid-run
    pdn_n = 1'b0;
    repeat (3) @(negedge clk);
    exp_speed = 0; exp_code = 4; exp_valid = 0; exp_err = 0;
    chk_all("R1 power-down mid-run");
    auto_sel = 1'b0;
    pdn_n = 1'b1;

    // R4: manual sweep
    sweep(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule